// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in-first-out buffer for 9-bit words that joins two unrelated clock domains. Words go in on the write clock and come out on the read clock, and the two clocks may run at any ratio. Storage is a small register array whose depth is a power-of-two parameter. Each side keeps its own binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other domain through a two-flop synchroniser, and that side's flags are derived from it.

The read timing is picked once, from the `tmode_sel` input while master reset is held. In standard timing, `out_flag` means empty, `in_flag` means full, and a word reaches `rd_q` one read clock after it is requested. In fall-through timing, `out_flag` means a word is waiting at `rd_q`, and `in_flag` means there is room for a write. The oldest word moves to `rd_q` by itself, and asserting `rd_en` consumes it.

A half-full flag, a rewind that sends reading back to the first stored word, a partial reset and an output-enable mask complete the block. The partial reset clears the data and keeps the chosen timing.

Top module: `xfifo_dual`

## Requirements
- R1: After master reset with `tmode_sel`=0 (standard timing), `out_flag` (empty) is 1, `in_flag` (full) is 0 and `half_flag` is 0. `in_flag` rises in the same write cycle in which the FIFO comes to hold DEPTH words.
- R2: In standard timing, a read with `rd_en`=1 while not empty puts the oldest word on `rd_q` after that read-clock edge, in write order. `rd_q` holds its value while no read takes place.
- R3: A write while full and a read while empty are ignored: the data is not stored, the pointers do not move, and `rd_q` does not change.
- R4: `half_flag` is 1 exactly when the occupancy seen on the write side is greater than DEPTH/2.
- R5: In fall-through timing, the first word written to an empty FIFO appears on `rd_q` with `out_flag`=1 and no read request. `rd_en` consumes the word shown. `in_flag` is 1 while fewer than DEPTH words are held in the array.
- R6: In standard timing, the empty indication falls after the second read-clock edge that follows the write-clock edge storing the first word. It is still 1 after the first such edge.
- R7: A one-cycle `rewind` pulse on the read clock sends the read pointer back to location 0. Subsequent reads then return the words again from the first one written since reset.
- R8: Master reset empties the FIFO and loads the read timing from `tmode_sel`, where 0 is standard and 1 is fall-through. After master reset in fall-through timing, `out_flag` is 0 and `in_flag` is 1.
- R9: Partial reset empties the FIFO and keeps the read timing that was loaded at the last master reset.
- R10: When `out_en` is 0, `rd_q` is 0 and `rd_q_mask` is all zeros. When `out_en` is 1, `rd_q_mask` is all ones and `rd_q` carries the output word.
- R11: A change on `tmode_sel` while master reset is low has no effect on the read timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, held across edges of both clocks |
| prst | input | 1 | Partial reset, active high, held across edges of both clocks |
| tmode_sel | input | 1 | Read timing choice, sampled while `mrst` is 1 (0 standard, 1 fall-through) |
| wr_en | input | 1 | Write request, write clock domain |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request or consume, read clock domain |
| rewind | input | 1 | Return reading to location 0, read clock domain |
| out_en | input | 1 | Output enable, applied as a mask |
| rd_q | output | DW | Output word, zero when masked |
| rd_q_mask | output | DW | Per-bit valid mask for `rd_q` |
| in_flag | output | 1 | Full in standard timing, input-ready in fall-through timing |
| out_flag | output | 1 | Empty in standard timing, output-ready in fall-through timing |
| half_flag | output | 1 | More than DEPTH/2 words held |

## Verification
A wrong pointer or a Gray code that is not converted properly shows first as a misplaced flag. Examples are a full indication one write early or late, a half flag on the wrong count, or an empty flag that never falls. On the write side the error appears in the write cycle that causes it. On the read side it appears within three read clocks, once the synchroniser has carried it across. A read pointer that moves when it should not shows at `rd_q` on the next read as a repeated or skipped word. A wrong timing register shows in the very first sample after reset, because the meaning of `out_flag` reverses.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

    localparam int WORD_W = 9;
    localparam int GRAY_MAX = 32;

    typedef enum logic {
        TM_STANDARD = 1'b0,
        TM_FALLTHRU = 1'b1
    } tmode_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] dat;
    } oword_t;

    function automatic logic [GRAY_MAX-1:0] to_gray(input logic [GRAY_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX-1:0] from_gray(input logic [GRAY_MAX-1:0] g);
        logic [GRAY_MAX-1:0] b;
        b[GRAY_MAX-1] = g[GRAY_MAX-1];
        for (int i = GRAY_MAX-2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
module xfifo_store #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdat;
        end
    end

    assign rdat = cells[raddr];
endmodule

// File: rtl/xfifo_mode.sv
`timescale 1ns/1ps
module xfifo_mode
    import xfifo_pkg::*;
(
    input  logic   clk,
    input  logic   mrst,
    input  logic   sel,
    output tmode_e mode
);
    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= tmode_e'(sel);
        end
    end
endmodule

// File: rtl/xfifo_wside.sv
`timescale 1ns/1ps
module xfifo_wside
    import xfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [AW:0] rgray_s,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        push,
    output logic        full,
    output logic        half
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] HALF_LVL = PW'(DEPTH / 2);

    logic [AW:0] rbin_s;
    logic [AW:0] level;
    logic [AW:0] wptr_nx;
    logic [GRAY_MAX-1:0] rbin_wide;
    logic [GRAY_MAX-1:0] wgray_wide;

    // Full: pointers differ only in the two top Gray bits.
    assign full = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign push = wr_en && !full;

    assign rbin_wide = from_gray(GRAY_MAX'(rgray_s));
    assign rbin_s    = rbin_wide[AW:0];
    assign level     = wptr - rbin_s;
    assign half      = (level > HALF_LVL);

    assign wptr_nx    = wptr + 1'b1;
    assign wgray_wide = to_gray(GRAY_MAX'(wptr_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (push) begin
            wptr  <= wptr_nx;
            wgray <= wgray_wide[AW:0];
        end
    end
endmodule

// File: rtl/xfifo_rside.sv
`timescale 1ns/1ps
module xfifo_rside
    import xfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  tmode_e            mode,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic [AW:0]       wgray_s,
    input  logic [WORD_W-1:0] mem_q,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rptr,
    output logic [AW:0]       rgray,
    output logic              mem_empty,
    output oword_t            ow
);
    logic        fetch;
    logic [AW:0] rptr_nx;
    logic [GRAY_MAX-1:0] rgray_wide;

    assign mem_empty = (rgray == wgray_s);
    assign raddr     = rptr[AW-1:0];

    always_comb begin
        if (mode == TM_FALLTHRU) begin
            fetch = !mem_empty && (!ow.vld || rd_en);
        end else begin
            fetch = !mem_empty && rd_en;
        end
    end

    assign rptr_nx    = rptr + 1'b1;
    assign rgray_wide = to_gray(GRAY_MAX'(rptr_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            rgray <= '0;
            ow    <= '0;
        end else if (rewind) begin
            rptr   <= '0;
            rgray  <= '0;
            ow.vld <= 1'b0;
        end else if (fetch) begin
            rptr   <= rptr_nx;
            rgray  <= rgray_wide[AW:0];
            ow.dat <= mem_q;
            ow.vld <= 1'b1;
        end else if (mode == TM_FALLTHRU && rd_en) begin
            ow.vld <= 1'b0;
        end
    end
endmodule

// File: rtl/xfifo_dual.sv
`timescale 1ns/1ps
module xfifo_dual
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = WORD_W
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          tmode_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic          out_en,
    output logic [DW-1:0] rd_q,
    output logic [DW-1:0] rd_q_mask,
    output logic          in_flag,
    output logic          out_flag,
    output logic          half_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          clr;
    tmode_e        mode_w;
    tmode_e        mode_r;
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_rs;
    logic [AW:0]   rgray_ws;
    logic          push;
    logic          full;
    logic          mem_empty;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_q;
    oword_t        ow;

    assign clr = mrst || prst;

    xfifo_mode u_mode_w (.clk(wr_clk), .mrst(mrst), .sel(tmode_sel), .mode(mode_w));
    xfifo_mode u_mode_r (.clk(rd_clk), .mrst(mrst), .sel(tmode_sel), .mode(mode_r));

    xfifo_wside #(.AW(AW)) u_wside (
        .clk(wr_clk), .rst(clr), .wr_en(wr_en), .rgray_s(rgray_ws),
        .wptr(wr_ptr), .wgray(wgray), .push(push), .full(full), .half(half_flag)
    );

    xfifo_store #(.AW(AW), .DW(DW)) u_store (
        .wclk(wr_clk), .we(push), .waddr(wr_ptr[AW-1:0]), .wdat(wr_data),
        .raddr(raddr), .rdat(mem_q)
    );

    xfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(clr), .d(wgray), .q(wgray_rs));
    xfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(clr), .d(rgray), .q(rgray_ws));

    xfifo_rside #(.AW(AW)) u_rside (
        .clk(rd_clk), .rst(clr), .mode(mode_r), .rd_en(rd_en), .rewind(rewind),
        .wgray_s(wgray_rs), .mem_q(mem_q), .raddr(raddr), .rptr(rd_ptr),
        .rgray(rgray), .mem_empty(mem_empty), .ow(ow)
    );

    assign in_flag   = (mode_w == TM_FALLTHRU) ? !full : full;
    assign out_flag  = (mode_r == TM_FALLTHRU) ? ow.vld : mem_empty;
    assign rd_q      = out_en ? ow.dat : '0;
    assign rd_q_mask = {DW{out_en}};
endmodule

// File: rtl/xfifo_dual_chk.sv
`timescale 1ns/1ps
module xfifo_dual_chk
    import xfifo_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rewind,
    input logic          out_en,
    input logic          full,
    input logic          mem_empty,
    input logic          half_flag,
    input logic [DW-1:0] rd_q,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rd_ptr,
    input tmode_e        mode_r
);
    // R3
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        full && wr_en |=> wr_ptr == $past(wr_ptr));

    // R3
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        mem_empty && rd_en && !rewind |=> rd_ptr == $past(rd_ptr));

    // R4
    full_half_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        full |-> half_flag);

    // R2
    std_advance_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (mode_r == TM_STANDARD) && rd_en && !mem_empty && !rewind
        |=> rd_ptr == $past(rd_ptr) + 1'b1);

    // R7
    rewind_home_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        rewind |=> rd_ptr == '0);

    // R11
    mode_hold_chk: assert property (@(posedge rd_clk) disable iff (mrst)
        1'b1 |=> $stable(mode_r));

    // R10
    oe_mask_chk: assert property (@(posedge rd_clk) disable iff (mrst)
        !out_en |-> rd_q == '0);
endmodule

bind xfifo_dual xfifo_dual_chk #(.AW(AW), .DW(DW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind), .out_en(out_en),
    .full(full), .mem_empty(mem_empty), .half_flag(half_flag), .rd_q(rd_q),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .mode_r(mode_r)
);

// File: tb/sim_xfifo_dual.sv
`timescale 1ns/1ps
module sim_xfifo_dual;
    localparam realtime WR_PERIOD = 10.0;
    localparam realtime RD_PERIOD = 13.0;
    localparam int DEPTH = 16;
    localparam int DW = 9;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic mrst = 1'b1;
    logic prst = 1'b0;
    logic tmode_sel = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic rewind = 1'b0;
    logic out_en = 1'b1;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_q_mask;
    logic in_flag;
    logic out_flag;
    logic half_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #(WR_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2) rclk = ~rclk;

    xfifo_dual #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .wr_clk(wclk), .rd_clk(rclk), .mrst(mrst), .prst(prst),
        .tmode_sel(tmode_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind(rewind), .out_en(out_en), .rd_q(rd_q),
        .rd_q_mask(rd_q_mask), .in_flag(in_flag), .out_flag(out_flag),
        .half_flag(half_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic master, input logic sel);
        @(negedge wclk);
        mrst = master;
        prst = !master;
        tmode_sel = sel;
        repeat (4) @(negedge wclk);
        mrst = 1'b0;
        prst = 1'b0;
    endtask

    task automatic push(input int v);
        @(negedge wclk);
        wr_en = 1'b1;
        wr_data = DW'(v);
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic pull();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
    endtask

    function automatic int sval(input int i);
        return (i * 37 + 5) & 9'h1FF;
    endfunction

    function automatic int fval(input int i);
        return (i * 53 + 17) & 9'h1FF;
    endfunction

    initial begin
        repeat (200000) @(posedge wclk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Standard timing after master reset
        do_reset(1'b1, 1'b0);
        @(negedge wclk);
        chk("R1 empty after reset", out_flag, 1);
        chk("R1 full after reset", in_flag, 0);
        chk("R8 half after reset", half_flag, 0);

        // First word latency (R6)
        @(negedge wclk);
        wr_en = 1'b1;
        wr_data = DW'(sval(0));
        @(posedge wclk);
        #1 wr_en = 1'b0;
        @(posedge rclk);
        @(negedge rclk);
        chk("R6 empty after one read edge", out_flag, 1);
        repeat (2) @(posedge rclk);
        @(negedge rclk);
        chk("R6 empty after sync", out_flag, 0);

        // Fill sweep (R1, R4)
        for (int i = 1; i < DEPTH; i++) begin
            push(sval(i));
            chk("R4 half flag level", half_flag, (i + 1 > DEPTH / 2) ? 1 : 0);
            chk("R1 full flag level", in_flag, (i + 1 == DEPTH) ? 1 : 0);
        end
        push(9'h1FF);
        chk("R3 full after ignored write", in_flag, 1);
        settle();

        // Drain (R2)
        for (int i = 0; i < DEPTH; i++) begin
            pull();
            chk("R2 read order", rd_q, sval(i));
        end
        chk("R3 empty after drain", out_flag, 1);
        repeat (3) @(negedge rclk);
        chk("R2 hold without read", rd_q, sval(DEPTH - 1));
        pull();
        chk("R3 read on empty ignored", rd_q, sval(DEPTH - 1));
        chk("R3 still empty", out_flag, 1);
        settle();
        chk("R4 half cleared", half_flag, 0);
        chk("R1 full cleared", in_flag, 0);

        // Rewind (R7) after partial reset
        do_reset(1'b0, 1'b0);
        @(negedge wclk);
        chk("R9 empty after partial reset", out_flag, 1);
        for (int i = 0; i < 5; i++) push(9'h100 | (i * 3));
        settle();
        for (int i = 0; i < 3; i++) begin
            pull();
            chk("R7 before rewind", rd_q, 9'h100 | (i * 3));
        end
        @(negedge rclk);
        rewind = 1'b1;
        @(negedge rclk);
        rewind = 1'b0;
        for (int i = 0; i < 5; i++) begin
            pull();
            chk("R7 after rewind", rd_q, 9'h100 | (i * 3));
        end
        chk("R7 empty after replay", out_flag, 1);

        // Fall-through timing (R8, R5)
        do_reset(1'b1, 1'b1);
        @(negedge wclk);
        chk("R8 not ready after reset", out_flag, 0);
        chk("R8 input ready after reset", in_flag, 1);
        push(9'h0AA);
        settle();
        chk("R5 falls through flag", out_flag, 1);
        chk("R5 falls through data", rd_q, 9'h0AA);
        for (int k = 0; k < DEPTH; k++) begin
            push(fval(k));
            chk("R5 input ready level", in_flag, (k < DEPTH - 1) ? 1 : 0);
        end
        push(9'h155);
        chk("R3 write on full ignored", in_flag, 0);
        settle();
        for (int j = 0; j <= DEPTH; j++) begin
            chk("R5 word shown", rd_q, (j == 0) ? 9'h0AA : fval(j - 1));
            chk("R5 ready while words", out_flag, 1);
            pull();
        end
        chk("R5 not ready after last", out_flag, 0);

        // Mode kept across partial reset, select ignored (R9, R11)
        @(negedge wclk);
        tmode_sel = 1'b0;
        do_reset(1'b0, 1'b0);
        @(negedge wclk);
        chk("R11 fall-through kept", out_flag, 0);
        push(9'h0C3);
        settle();
        chk("R9 fall-through after partial", out_flag, 1);
        chk("R9 data after partial", rd_q, 9'h0C3);

        // Output enable (R10)
        @(negedge wclk);
        out_en = 1'b0;
        #1;
        chk("R10 masked data", rd_q, 0);
        chk("R10 masked mask", rd_q_mask, 0);
        out_en = 1'b1;
        #1;
        chk("R10 enabled data", rd_q, 9'h0C3);
        chk("R10 enabled mask", rd_q_mask, 9'h1FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule